// File: doc/BRIEF.md
# Writeback Frame Capture Controller

This block is the register front end and frame sequencer of a display writeback engine, the unit that copies composited frames into memory. Software programs a destination address, a line stride in bytes and the image size through a small bank of 32-bit registers. It then starts a capture by setting a self-clearing start bit in the control word. From then on the block tracks the frame. A line counter advances on each strobe from the pixel datapath that says a line has reached memory. The busy flag drops once the counter reaches the programmed height, and the idle interrupt can then fire.

The pixel path itself is outside this block. It sees a start pulse, an abort pulse and a memory power-down level, plus the programmed geometry. It reports back only through the per-line commit strobe. Software may end a frame early with a self-clearing abort bit. It acknowledges the interrupt by clearing the interrupt-enable bit. The upper byte and two bits below it of the control word form a fixed identification value.

Top module: `wbk_ctrl_regs`

## Requirements
- R1: After reset, the address, stride, size and line-count registers read 0, the control word reads 0x5440_0000, the block is idle and `irq` is low.
- R2: The address register (offset 0x00) reads back with bits [1:0] forced to 0. The stride register (offset 0x04) reads back with bits [3:0] forced to 0. The size register (offset 0x08) holds height in [31:16] and width in [15:0]. All three also appear on the matching output ports.
- R3: Writing the control word (offset 0x0C) with bit 0 set while idle starts a frame. Busy (bit 1) reads 1 from the next cycle, `frame_start` pulses for one cycle, and bit 0 always reads 0.
- R4: Starting a frame clears the line count (offset 0x10) to 0. While busy, each `line_commit` cycle adds one, up to the programmed height.
- R5: One cycle after the line count equals the height, busy clears and `frame_done` pulses for one cycle. With height 0, busy lasts exactly one cycle.
- R6: A control write with bit 14 set while busy clears busy at once and pulses `abort_req`. The line count holds, `frame_done` stays low and bit 14 reads 0. A write that sets both bit 0 and bit 14 while idle starts no frame.
- R7: A start written while busy is ignored: the line count is not cleared and no `frame_start` pulse occurs.
- R8: Bit 21 is memory power-down: it reads back and drives `mem_pd`. A start is ignored when power-down is already set, or when the same write sets it.
- R9: `irq` is high exactly when interrupt-enable (bit 2) is set and the block is idle. Writing bit 2 as 0 lowers it.
- R10: Bits [31:24] always read 0x54 and bits [23:22] always read 01, whatever is written.
- R11: `line_commit` strobes while idle leave the line count unchanged.
- R12: Offsets other than the five registers read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| line_commit | input | 1 | One line has been committed to memory |
| frame_start | output | 1 | One-cycle pulse when a frame is started |
| frame_done | output | 1 | One-cycle pulse when a frame completes normally |
| abort_req | output | 1 | One-cycle pulse when a running frame is aborted |
| mem_pd | output | 1 | Internal memory power-down level |
| irq | output | 1 | Idle interrupt |
| dst_addr | output | 32 | Aligned destination address |
| dst_stride | output | 32 | Aligned line stride in bytes |
| img_width | output | 16 | Programmed width |
| img_height | output | 16 | Programmed height |

## Verification
The bench sweeps frame heights from zero upward. For each height it counts the exact cycle in which busy drops and in which the done pulse and interrupt appear. A design off by one in the end-of-frame compare would end a line early or late, and one that treats height 0 as "never" would hang busy. It aims restarts at a running frame, starts under a held or freshly written power-down, and start-plus-abort in one word. A design that let any of these through would reset the line count or raise a spurious start pulse. It also writes all-ones to every register and to unused offsets, which exposes a writable identification field, unmasked alignment bits or aliasing of the decode.

// File: rtl/wbk_pkg.sv
package wbk_pkg;

    localparam int REG_AW = 5;
    localparam int WORD_W = 32;

    localparam logic [REG_AW-1:0] OFS_DST   = 5'h00;
    localparam logic [REG_AW-1:0] OFS_PITCH = 5'h04;
    localparam logic [REG_AW-1:0] OFS_DIM   = 5'h08;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_PROG  = 5'h10;

    localparam int CB_GO    = 0;
    localparam int CB_BUSY  = 1;
    localparam int CB_IRQEN = 2;
    localparam int CB_ABORT = 14;
    localparam int CB_PD    = 21;

    localparam logic [7:0] ID_TAG = 8'h54;
    localparam logic [1:0] ID_REV = 2'b01;

    typedef enum logic [2:0] {
        SEL_DST,
        SEL_PITCH,
        SEL_DIM,
        SEL_CTRL,
        SEL_PROG,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [REG_AW-1:0] a);
        case (a)
            OFS_DST:   return SEL_DST;
            OFS_PITCH: return SEL_PITCH;
            OFS_DIM:   return SEL_DIM;
            OFS_CTRL:  return SEL_CTRL;
            OFS_PROG:  return SEL_PROG;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] id_word();
        logic [WORD_W-1:0] w;
        w = '0;
        w[31:24] = ID_TAG;
        w[23:22] = ID_REV;
        return w;
    endfunction

endpackage

// File: rtl/wbk_cfg_regs.sv
module wbk_cfg_regs
    import wbk_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PTR_ALIGN   = 2,
    parameter int PITCH_ALIGN = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  reg_sel_e            sel,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   dst_q,
    output logic [DATA_W-1:0]   pitch_q,
    output logic [DATA_W/2-1:0] width_q,
    output logic [DATA_W/2-1:0] height_q,
    output logic                irq_en_q,
    output logic                pd_q
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:PTR_ALIGN]   ptr_hi;
    logic [DATA_W-1:PITCH_ALIGN] pitch_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_hi   <= '0;
            pitch_hi <= '0;
            width_q  <= '0;
            height_q <= '0;
            irq_en_q <= 1'b0;
            pd_q     <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_DST:   ptr_hi   <= wdata[DATA_W-1:PTR_ALIGN];
                SEL_PITCH: pitch_hi <= wdata[DATA_W-1:PITCH_ALIGN];
                SEL_DIM: begin
                    width_q  <= wdata[HALF_W-1:0];
                    height_q <= wdata[DATA_W-1:HALF_W];
                end
                SEL_CTRL: begin
                    irq_en_q <= wdata[CB_IRQEN];
                    pd_q     <= wdata[CB_PD];
                end
                default: ;
            endcase
        end
    end

    generate
        if (PTR_ALIGN > 0) begin : g_ptr_mask
            assign dst_q = {ptr_hi, {PTR_ALIGN{1'b0}}};
        end else begin : g_ptr_full
            assign dst_q = ptr_hi;
        end
        if (PITCH_ALIGN > 0) begin : g_pitch_mask
            assign pitch_q = {pitch_hi, {PITCH_ALIGN{1'b0}}};
        end else begin : g_pitch_full
            assign pitch_q = pitch_hi;
        end
    endgenerate

endmodule

// File: rtl/wbk_frame_seq.sv
module wbk_frame_seq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_go,
    input  logic             wr_abort,
    input  logic             wr_pd,
    input  logic             pd_q,
    input  logic [CNT_W-1:0] height,
    input  logic             line_commit,
    output logic             busy,
    output logic [CNT_W-1:0] progress,
    output logic             start_p,
    output logic             done_p,
    output logic             abort_p
);
    logic go_ok;
    logic abort_hit;
    logic finish;

    always_comb begin
        go_ok     = wr_ctrl && wr_go && !wr_abort && !busy && !pd_q && !wr_pd;
        abort_hit = wr_ctrl && wr_abort && busy;
        finish    = busy && (progress >= height) && !abort_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            progress <= '0;
            start_p  <= 1'b0;
            done_p   <= 1'b0;
            abort_p  <= 1'b0;
        end else begin
            start_p <= go_ok;
            done_p  <= finish;
            abort_p <= abort_hit;
            if (go_ok) begin
                busy     <= 1'b1;
                progress <= '0;
            end else if (abort_hit || finish) begin
                busy <= 1'b0;
            end else if (busy && line_commit) begin
                progress <= progress + 1'b1;
            end
        end
    end

    // R11: the line count only moves while a frame runs or a start clears it
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !go_ok) |=> $stable(progress));

    // R7: a start pulse only follows an idle cycle
    p_start_idle_r7: assert property (@(posedge clk) disable iff (rst)
        start_p |-> !$past(busy));

    // R5: a done pulse coincides with the fall of busy
    p_done_fall_r5: assert property (@(posedge clk) disable iff (rst)
        done_p |-> $fell(busy));

    // R6: an abort never reports as a completed frame
    p_abort_nodone_r6: assert property (@(posedge clk) disable iff (rst)
        abort_p |-> (!done_p && !busy));

    // R4: a new frame begins with an empty line count
    p_start_zero_r4: assert property (@(posedge clk) disable iff (rst)
        start_p |-> (busy && progress == '0));

endmodule

// File: rtl/wbk_rd_mux.sv
module wbk_rd_mux
    import wbk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  reg_sel_e            sel,
    input  logic [DATA_W-1:0]   dst_q,
    input  logic [DATA_W-1:0]   pitch_q,
    input  logic [DATA_W/2-1:0] width_q,
    input  logic [DATA_W/2-1:0] height_q,
    input  logic                irq_en_q,
    input  logic                pd_q,
    input  logic                busy,
    input  logic [CNT_W-1:0]    progress,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] ctrl_word;

    always_comb begin
        ctrl_word           = id_word();
        ctrl_word[CB_BUSY]  = busy;
        ctrl_word[CB_IRQEN] = irq_en_q;
        ctrl_word[CB_PD]    = pd_q;
    end

    always_comb begin
        case (sel)
            SEL_DST:   rdata = dst_q;
            SEL_PITCH: rdata = pitch_q;
            SEL_DIM:   rdata = {height_q, width_q};
            SEL_CTRL:  rdata = ctrl_word;
            SEL_PROG:  rdata = {{(DATA_W-CNT_W){1'b0}}, progress};
            default:   rdata = '0;
        endcase
    end

    // R10: identification bits are constant on every control read
    always_comb begin
        if (sel == SEL_CTRL) begin
            p_id_const_r10: assert (rdata[31:22] == {ID_TAG, ID_REV});
        end
    end

endmodule

// File: rtl/wbk_ctrl_regs.sv
module wbk_ctrl_regs
    import wbk_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PTR_ALIGN   = 2,
    parameter int PITCH_ALIGN = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [REG_AW-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                line_commit,
    output logic                frame_start,
    output logic                frame_done,
    output logic                abort_req,
    output logic                mem_pd,
    output logic                irq,
    output logic [DATA_W-1:0]   dst_addr,
    output logic [DATA_W-1:0]   dst_stride,
    output logic [DATA_W/2-1:0] img_width,
    output logic [DATA_W/2-1:0] img_height
);
    localparam int HALF_W = DATA_W / 2;

    reg_sel_e          sel;
    logic              wr_ctrl;
    logic              irq_en_q;
    logic              pd_q;
    logic              busy;
    logic [HALF_W-1:0] progress;

    assign sel     = decode_ofs(bus_addr);
    assign wr_ctrl = bus_wr && (sel == SEL_CTRL);

    wbk_cfg_regs #(
        .DATA_W      (DATA_W),
        .PTR_ALIGN   (PTR_ALIGN),
        .PITCH_ALIGN (PITCH_ALIGN)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .sel      (sel),
        .wdata    (bus_wdata),
        .dst_q    (dst_addr),
        .pitch_q  (dst_stride),
        .width_q  (img_width),
        .height_q (img_height),
        .irq_en_q (irq_en_q),
        .pd_q     (pd_q)
    );

    wbk_frame_seq #(
        .CNT_W (HALF_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .wr_ctrl     (wr_ctrl),
        .wr_go       (bus_wdata[CB_GO]),
        .wr_abort    (bus_wdata[CB_ABORT]),
        .wr_pd       (bus_wdata[CB_PD]),
        .pd_q        (pd_q),
        .height      (img_height),
        .line_commit (line_commit),
        .busy        (busy),
        .progress    (progress),
        .start_p     (frame_start),
        .done_p      (frame_done),
        .abort_p     (abort_req)
    );

    wbk_rd_mux #(
        .DATA_W (DATA_W),
        .CNT_W  (HALF_W)
    ) u_rd (
        .sel      (sel),
        .dst_q    (dst_addr),
        .pitch_q  (dst_stride),
        .width_q  (img_width),
        .height_q (img_height),
        .irq_en_q (irq_en_q),
        .pd_q     (pd_q),
        .busy     (busy),
        .progress (progress),
        .rdata    (bus_rdata)
    );

    assign mem_pd = pd_q;
    assign irq    = irq_en_q && !busy;

    // R9: the interrupt is never raised during a frame
    p_irq_idle_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy);

    // R8: a frame never starts with the memory powered down
    p_start_powered_r8: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !mem_pd);

    // R9: completing a frame with the enable set raises the interrupt
    p_done_irq_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_done && irq_en_q) |-> irq);

endmodule

// File: tb/test_wbk_ctrl_regs.sv
module test_wbk_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        line_commit = 1'b0;
    logic        frame_start, frame_done, abort_req, mem_pd, irq;
    logic [31:0] dst_addr, dst_stride;
    logic [15:0] img_width, img_height;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [31:0] IDW = 32'h5440_0000;

    always #2.5 clk = ~clk;

    wbk_ctrl_regs i_wbk_ctrl_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_commit(line_commit),
        .frame_start(frame_start), .frame_done(frame_done), .abort_req(abort_req),
        .mem_pd(mem_pd), .irq(irq), .dst_addr(dst_addr), .dst_stride(dst_stride),
        .img_width(img_width), .img_height(img_height)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic line();
        @(negedge clk);
        line_commit = 1'b1;
        @(negedge clk);
        line_commit = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pats [6];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h1234_5677; pats[2] = 32'h0000_000F;
        pats[3] = 32'hA5A5_A5A5; pats[4] = 32'h8000_0013; pats[5] = 32'h0000_0000;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, v); chk("R1 dst", v, 0);
        rd(5'h04, v); chk("R1 pitch", v, 0);
        rd(5'h08, v); chk("R1 dim", v, 0);
        rd(5'h0C, v); chk("R1 ctrl", v, IDW);
        rd(5'h10, v); chk("R1 progress", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 alignment and field placement
        foreach (pats[i]) begin
            wr(5'h00, pats[i]); wr(5'h04, ~pats[i]);
            rd(5'h00, v); chk("R2 dst read", v, pats[i] & 32'hFFFF_FFFC);
            chk("R2 dst port", dst_addr, pats[i] & 32'hFFFF_FFFC);
            rd(5'h04, v); chk("R2 pitch read", v, ~pats[i] & 32'hFFFF_FFF0);
            chk("R2 pitch port", dst_stride, ~pats[i] & 32'hFFFF_FFF0);
            wr(5'h08, pats[i]);
            chk("R2 width", {16'd0, img_width}, {16'd0, pats[i][15:0]});
            chk("R2 height", {16'd0, img_height}, {16'd0, pats[i][31:16]});
        end

        // R3 R4 R5 R9 R11 sweep over heights
        for (int h = 0; h <= 6; h++) begin
            wr(5'h08, {h[15:0], 16'(h * 3 + 1)});
            wr(5'h0C, 32'h0000_0005);
            chk("R3 frame_start", {31'd0, frame_start}, 1);
            rd(5'h0C, v); chk("R3 ctrl busy, go reads 0", v, IDW | 32'h6);
            rd(5'h10, v); chk("R4 progress cleared", v, 0);
            chk("R9 irq low while busy", {31'd0, irq}, 0);
            for (int k = 0; k < h; k++) begin
                line();
                rd(5'h10, v); chk("R4 progress count", v, k + 1);
                rd(5'h0C, v); chk("R5 still busy", {31'd0, v[1]}, 1);
            end
            @(negedge clk);
            rd(5'h0C, v); chk("R5 busy cleared", {31'd0, v[1]}, 0);
            chk("R5 frame_done", {31'd0, frame_done}, 1);
            chk("R9 irq when idle", {31'd0, irq}, 1);
            @(negedge clk);
            chk("R5 done one cycle", {31'd0, frame_done}, 0);
            line(); line();
            rd(5'h10, v); chk("R11 idle lines ignored", v, h);
            wr(5'h0C, 32'h0);
            chk("R9 irq acknowledged", {31'd0, irq}, 0);
        end

        // R7 restart ignored, R6 abort
        wr(5'h08, {16'd4, 16'd8});
        wr(5'h0C, 32'h1);
        line(); line();
        wr(5'h0C, 32'h1);
        chk("R7 no start pulse", {31'd0, frame_start}, 0);
        rd(5'h10, v); chk("R7 progress kept", v, 2);
        wr(5'h0C, 32'h0000_4004);
        chk("R6 abort pulse", {31'd0, abort_req}, 1);
        chk("R6 no done", {31'd0, frame_done}, 0);
        rd(5'h0C, v); chk("R6 idle, abort reads 0", v, IDW | 32'h4);
        rd(5'h10, v); chk("R6 progress held", v, 2);
        line();
        rd(5'h10, v); chk("R11 after abort", v, 2);
        wr(5'h0C, 32'h0000_4001);
        rd(5'h0C, v); chk("R6 go+abort idle", {31'd0, v[1]}, 0);

        // R8 power-down blocks start
        wr(5'h0C, 32'h0020_0001);
        chk("R8 mem_pd set", {31'd0, mem_pd}, 1);
        rd(5'h0C, v); chk("R8 same-write go ignored", v, IDW | 32'h0020_0000);
        wr(5'h0C, 32'h1);
        chk("R8 held pd go ignored", {31'd0, frame_start}, 0);
        chk("R8 pd cleared", {31'd0, mem_pd}, 0);
        wr(5'h0C, 32'h1);
        chk("R8 start after pd off", {31'd0, frame_start}, 1);
        wr(5'h0C, 32'h0000_4000);

        // R10 constant id
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, v); chk("R10 id constant", v, 32'h5460_0004);
        wr(5'h0C, 32'h0);
        rd(5'h0C, v); chk("R10 id after zero", v, IDW);

        // R12 unmapped offsets
        wr(5'h00, 32'h1111_1110);
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h14, v); chk("R12 unmapped read", v, 0);
        rd(5'h18, v); chk("R12 unmapped read2", v, 0);
        rd(5'h00, v); chk("R12 dst untouched", v, 32'h1111_1110);
        rd(5'h0C, v); chk("R12 ctrl untouched", v, IDW);

        finish_run();
    end
endmodule